// File: doc/BRIEF.md
# 16-to-8-Bit Bus Transfer Splitter

This block sits between a 16-bit host port and a shared data bus on which some targets are a full word wide and others only a byte wide. The host hands over one request at a time: a word address, write data, two byte enables, a read/write flag and a flag saying whether the addressed target is 16 bits wide. The block then issues the bus cycles that the request needs and answers the host with a single completion pulse. For reads, it also returns a 16-bit read word.

A wide target gets one word cycle carrying the host's byte enables. A byte-wide target only ever sees the low lane. When both bytes are enabled, the block makes two byte cycles: the even address goes first and the odd address follows. The upper host byte is moved down onto bits 7..0 for its cycle. On the read side, the first returned byte is parked in a register. The host gets the combined word only after the second cycle completes. A request with a single enabled byte costs one bus cycle, and a request with no enabled byte costs none. How long each bus cycle lasts is up to the bus side, which ends a cycle with a done strobe.

Top module: `bus_width_splitter`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `cyc_req` is 0 and `rsp_done` is 0, and no bus cycle is requested while `req_ready` is 1.
- R2: When `req_wide` is 1 and at least one enable is set, exactly one bus cycle is issued. It has `cyc_wide`=1, an even `cyc_addr` equal to the request address with bit 0 cleared, `cyc_be` equal to `req_be`, and `cyc_wdata` equal to `req_wdata`.
- R3: When `req_wide` is 0 and `req_be`=2'b11, two bus cycles are issued in order. The first goes to the even base address and the second to base+1.
- R4: In every byte cycle (`cyc_wide`=0), `cyc_be` is 2'b01 and `cyc_wdata[15:8]` is zero. `cyc_wdata[7:0]` carries `req_wdata[7:0]` when `cyc_addr` is even and `req_wdata[15:8]` when it is odd.
- R5: On a two-byte read from a byte-wide target, the byte returned on `bus_rdata[7:0]` by the even-address cycle appears in `rsp_rdata[7:0]`. The byte returned by the odd-address cycle appears in `rsp_rdata[15:8]`. `bus_rdata[15:8]` is ignored in byte cycles.
- R6: For a byte-wide target with a single enabled byte, exactly one cycle is issued. With `req_be`=2'b01 it goes to the base address, and with 2'b10 it goes to base+1. On a read, the returned byte lands in its own half of `rsp_rdata` and the other half is zero.
- R7: A request with `req_be`=2'b00 issues no bus cycle. `rsp_done` is raised in the cycle after acceptance.
- R8: Each accepted request produces exactly one `rsp_done` pulse, one clock long, in the cycle after the last `cyc_done`. `req_ready` is 0 from acceptance until that pulse has ended.
- R9: While `cyc_req` is 1 and `cyc_done` is 0, `cyc_req`, `cyc_addr`, `cyc_wide`, `cyc_be` and `cyc_wdata` hold their values into the next cycle.
- R10: On reads from a wide target, `rsp_rdata` is `bus_rdata` with the byte of every disabled enable forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Addressed target is 16 bits wide |
| req_addr | input | ADDR_W | Host address (bit 0 ignored) |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_wdata | input | 16 | Host write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Assembled read word |
| cyc_req | output | 1 | Bus cycle requested |
| cyc_write | output | 1 | Bus cycle direction |
| cyc_wide | output | 1 | 1 = word cycle, 0 = byte cycle on low lane |
| cyc_addr | output | ADDR_W | Bus cycle address |
| cyc_be | output | 2 | Bus cycle byte enables |
| cyc_wdata | output | 16 | Bus cycle write data |
| cyc_done | input | 1 | Current bus cycle finished |
| bus_rdata | input | 16 | Read data, valid with cyc_done |

## Verification
The bench sweeps every combination of target width, direction and all four byte-enable codes over even, odd and top-of-range addresses. The enable codes separate the zero-, one- and two-cycle paths, and the odd address shows that bit 0 is dropped. The bus model returns different bytes for every address and puts junk on the upper lane in byte cycles. A wrong lane, a swapped order or a missing zero mask therefore changes the read word. The cycle-done strobe is delayed by zero to two cycles in rotation, which tests both the hold rule and the placement of the completion pulse.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_RESP   = 2'd3
  } phase_e;

  // Select one lane of a word.
  function automatic logic [LANE_W-1:0] pick_lane(input logic [WORD_W-1:0] w, input logic upper);
    return upper ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction

  // Put a byte into one lane of an otherwise zero word.
  function automatic logic [WORD_W-1:0] place_lane(input logic [LANE_W-1:0] b, input logic upper);
    return upper ? {b, {LANE_W{1'b0}}} : {{LANE_W{1'b0}}, b};
  endfunction

  // Clear the bytes whose enable is off.
  function automatic logic [WORD_W-1:0] mask_word(input logic [WORD_W-1:0] w, input logic [1:0] be);
    return {w[WORD_W-1:LANE_W] & {LANE_W{be[1]}}, w[LANE_W-1:0] & {LANE_W{be[0]}}};
  endfunction
endpackage

// File: rtl/bws_plan.sv
module bws_plan
  import bws_pkg::*;
(
  input  logic [1:0] be,
  input  logic       wide,
  output logic       no_cycle,
  output logic       two_cycles,
  output logic       start_upper
);
  always_comb begin
    no_cycle    = (be == 2'b00);
    two_cycles  = !wide && (be == 2'b11);
    start_upper = !wide && (be == 2'b10);
  end
endmodule

// File: rtl/bws_lane_mux.sv
module bws_lane_mux
  import bws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        be_in,
  input  logic              wide,
  input  logic              upper,
  output logic [WORD_W-1:0] lane_data,
  output logic [1:0]        lane_be
);
  always_comb begin
    if (wide) begin
      lane_data = word_in;
      lane_be   = be_in;
    end else begin
      lane_data = place_lane(pick_lane(word_in, upper), 1'b0);
      lane_be   = 2'b01;
    end
  end

  AST_NARROW_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wide) |-> (lane_data[WORD_W-1:LANE_W] == '0 && lane_be == 2'b01)); // R4
endmodule

// File: rtl/bws_gather.sv
module bws_gather
  import bws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              wide,
  input  logic              upper,
  input  logic [1:0]        be,
  input  logic [WORD_W-1:0] bus_word,
  output logic [WORD_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (capture) begin
      if (wide) acc <= mask_word(bus_word, be);
      else      acc <= acc | place_lane(pick_lane(bus_word, 1'b0), upper);
    end
  end

  AST_KEEP_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !wide && !upper && !clear) |=> acc[WORD_W-1:LANE_W] == $past(acc[WORD_W-1:LANE_W])); // R5
endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
  import bws_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              cyc_req,
  output logic              cyc_write,
  output logic              cyc_wide,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [1:0]        cyc_be,
  output logic [WORD_W-1:0] cyc_wdata,
  input  logic              cyc_done,
  input  logic [WORD_W-1:0] bus_rdata
);
  phase_e            phase;
  logic [ADDR_W-1:0] r_base;
  logic [WORD_W-1:0] r_wdata;
  logic [1:0]        r_be;
  logic              r_wide, r_write, r_two, r_upper;

  logic accept, cycle_end, plan_none, plan_two, plan_upper;

  assign accept    = req_valid && (phase == PH_IDLE);
  assign cycle_end = cyc_req && cyc_done;

  bws_plan u_plan (
    .be          (req_be),
    .wide        (req_wide),
    .no_cycle    (plan_none),
    .two_cycles  (plan_two),
    .start_upper (plan_upper)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      r_base  <= '0;
      r_wdata <= '0;
      r_be    <= '0;
      r_wide  <= 1'b0;
      r_write <= 1'b0;
      r_two   <= 1'b0;
      r_upper <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          r_base  <= {req_addr[ADDR_W-1:1], 1'b0};
          r_wdata <= req_wdata;
          r_be    <= req_be;
          r_wide  <= req_wide;
          r_write <= req_write;
          r_two   <= plan_two;
          r_upper <= plan_upper;
          phase   <= plan_none ? PH_RESP : PH_FIRST;
        end
        PH_FIRST: if (cyc_done) begin
          if (r_two) begin
            r_upper <= 1'b1;
            phase   <= PH_SECOND;
          end else begin
            phase   <= PH_RESP;
          end
        end
        PH_SECOND: if (cyc_done) phase <= PH_RESP;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign rsp_done  = (phase == PH_RESP);
  assign cyc_req   = (phase == PH_FIRST) || (phase == PH_SECOND);
  assign cyc_write = r_write;
  assign cyc_wide  = r_wide;
  assign cyc_addr  = r_base | ADDR_W'(r_upper && !r_wide);

  bws_lane_mux u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (cyc_req),
    .word_in   (r_wdata),
    .be_in     (r_be),
    .wide      (r_wide),
    .upper     (r_upper),
    .lane_data (cyc_wdata),
    .lane_be   (cyc_be)
  );

  bws_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .capture  (cycle_end),
    .wide     (r_wide),
    .upper    (r_upper),
    .be       (r_be),
    .bus_word (bus_rdata),
    .acc      (rsp_rdata)
  );

  AST_IDLE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cyc_req); // R1
  AST_WIDE_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_wide) |-> !cyc_addr[0]); // R2
  AST_SECOND_FOLLOWS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && cyc_done && r_two) |=> (cyc_req && cyc_addr == $past(cyc_addr) + ADDR_W'(1))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready); // R8
  AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !cyc_done) |=> (cyc_req && $stable(cyc_addr) && $stable(cyc_wdata) && $stable(cyc_be) && $stable(cyc_wide))); // R9
endmodule

// File: tb/bus_width_splitter_tb.sv
module bus_width_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_done, cyc_req, cyc_write, cyc_wide;
  logic [15:0] rsp_rdata, cyc_wdata;
  logic [ADDR_W-1:0] cyc_addr;
  logic [1:0] cyc_be;
  logic cyc_done = 1'b0;
  logic [15:0] bus_rdata = '0;

  int tests = 0, fails = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_width_splitter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .cyc_req(cyc_req), .cyc_write(cyc_write),
    .cyc_wide(cyc_wide), .cyc_addr(cyc_addr), .cyc_be(cyc_be),
    .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] mem_b(input logic [ADDR_W-1:0] a);
    return 8'(a * 7 + 8'h13);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic run_txn(input logic [ADDR_W-1:0] addr, input bit wide, input bit wr,
                         input logic [1:0] be, input logic [15:0] wd, input int dly);
    logic [ADDR_W-1:0] base, e_addr[2];
    logic [15:0] e_wd[2], e_rd;
    logic [1:0] e_be[2];
    int n, idx, wcnt, since;
    bit done_seen;
    base = {addr[ADDR_W-1:1], 1'b0};
    n = 0;
    if (be != 2'b00) begin
      if (wide) begin
        e_addr[0] = base; e_wd[0] = wd; e_be[0] = be; n = 1;
      end else begin
        if (be[0]) begin e_addr[n] = base; e_wd[n] = {8'h00, wd[7:0]}; e_be[n] = 2'b01; n++; end
        if (be[1]) begin e_addr[n] = base + 1'b1; e_wd[n] = {8'h00, wd[15:8]}; e_be[n] = 2'b01; n++; end
      end
    end
    e_rd = {be[1] ? mem_b(base + 1'b1) : 8'h00, be[0] ? mem_b(base) : 8'h00};

    @(negedge clk);
    check(!rsp_done, "R8 pulse ends", 32'(rsp_done), 0);
    check(req_ready && !cyc_req, "R1 idle between requests", {cyc_req, req_ready}, 32'b01);
    req_valid = 1; req_addr = addr; req_wide = wide; req_write = wr; req_be = be; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    idx = 0; wcnt = 0; since = 0; done_seen = 0;
    for (int t = 0; t < 40 && !done_seen; t++) begin
      cyc_done = 0;
      since++;
      if (rsp_done) begin
        done_seen = 1;
        check(idx == n, wide ? "R2 cycle count" : (be == 2'b11 ? "R3 cycle count" : (be == 2'b00 ? "R7 cycle count" : "R6 cycle count")), idx, n);
        check(since == 1, be == 2'b00 ? "R7 done timing" : "R8 done timing", since, 1);
        if (!wr) check(rsp_rdata == e_rd, wide ? "R10 wide read" : (be == 2'b11 ? "R5 byte assembly" : "R6 single byte read"), rsp_rdata, e_rd);
      end else begin
        check(!req_ready, "R8 busy", 32'(req_ready), 0);
        if (cyc_req) begin
          if (idx >= n) begin
            check(0, "R7/R6 extra cycle", idx, n);
          end else begin
            check(cyc_addr == e_addr[idx] && cyc_wide == wide && cyc_write == wr,
                  wide ? "R2 address" : (idx == 1 ? "R3 order" : "R6 address"),
                  {cyc_wide, cyc_write, 6'd0, cyc_addr}, {wide, wr, 6'd0, e_addr[idx]});
            check(cyc_wdata == e_wd[idx] && cyc_be == e_be[idx], wide ? "R2 data" : "R4 lane steering",
                  {cyc_be, cyc_wdata}, {e_be[idx], e_wd[idx]});
            if (wcnt > 0) check(cyc_req, "R9 hold", 32'(cyc_req), 1);
            if (wcnt == dly) begin
              cyc_done = 1;
              bus_rdata = wide ? {mem_b(cyc_addr + 1'b1), mem_b(cyc_addr)} : {8'hEE, mem_b(cyc_addr)};
              idx++; wcnt = 0; since = 0;
            end else begin
              wcnt++;
            end
          end
        end
        @(posedge clk);
        @(negedge clk);
      end
    end
    cyc_done = 0;
    check(done_seen, "R8 done seen", 32'(done_seen), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] addrs[4];
    int k;
    addrs[0] = 8'h00; addrs[1] = 8'h55; addrs[2] = 8'h3E; addrs[3] = 8'hFE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !cyc_req && !rsp_done, "R1 reset state",
          {rsp_done, cyc_req, req_ready}, 32'b001);
    k = 0;
    for (int a = 0; a < 4; a++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
          for (int b = 0; b < 4; b++) begin
            run_txn(addrs[a], w[0], d[0], b[1:0],
                    {8'(addrs[a] ^ 8'hA5 ^ 8'(k)), 8'(addrs[a] ^ 8'h3C ^ 8'(b))}, k % 3);
            k++;
          end
    @(negedge clk);
    check(!rsp_done && req_ready, "R8 final idle", {rsp_done, req_ready}, 32'b01);
    finish_run();
  end
endmodule